// File: doc/BRIEF.md
# Memory Bandwidth Monitor Counter

This block watches the arbitration interface of a memory controller and counts traffic over a programmable sampling window. Each cycle it sees a request strobe and a grant strobe, along with the port ID and sub-port ID of the master that won the grant. Two global counters take every request and every grant. Four filter channels each keep their own grant count, and each channel counts only the masters that its filter selects.

Software uses a word-addressed register file, with byte offset equal to register index times four. It programs a window length and the channel filters, then sets the run bit. In timed mode a down-counter ends the window after the programmed number of cycles. At that point every counter freezes, the run bit drops and an interrupt flag is raised. The flag holds the interrupt output high until software writes a one to it. In free mode the counters run until software clears the run bit, and no interrupt is raised.

The window controller is a three-state machine:
- `ST_IDLE`: nothing counts.
- `ST_TIMED`: counting, and the timer decrements.
- `ST_FREE`: counting with no timer.

Its transitions are:
- START_TIMED: IDLE to TIMED on a control write with run=1 and timed=1.
- START_FREE: IDLE to FREE on a control write with run=1 and timed=0.
- EXPIRE: TIMED to IDLE when the remaining count is at most 1 and there is no control write. This raises the flag.
- ABORT: TIMED or FREE to IDLE on a control write with run=0. This raises no flag.
- RETIME: a control write with run=1 and timed=1 in TIMED or FREE. It enters or stays in TIMED and reloads the timer.
- UNTIME: TIMED to FREE on a control write with run=1 and timed=0.

Top module: `mem_bw_monitor`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Register index k sits at byte offset 4k. Filter channel n has a 32-bit port register at index 1+2n and a sub-port register at index 2+2n. The sub-port register keeps only bits 15:0, and its upper bits read zero. The timer register (index 15) reads back the value last written.
- R3: Index 9 counts request strobes and index 10 counts grant strobes. Both count on every cycle the monitor is running, whatever the filters hold. Neither changes while the monitor is stopped.
- R4: Port mode is selected when port-register bit 23 is clear. In this mode a grant adds to the channel count if the port-register bit at the granted port ID is set and the sub-port-register bit at the granted sub-port ID is set. A value of 0xFFFF accepts every sub-port.
- R5: Device mode is selected when port-register bit 23 is set. In this mode a grant adds to the channel count only if the granted port ID equals 23 and the sub-port-register bit at the granted sub-port ID (0 to 15) is set.
- R6: Control bits 3:0 enable channels 0 to 3. A channel whose bit is clear does not count, even when its filter matches. Channel n's count is at index 11+n.
- R7: A control write with bit 31 (run) and bit 20 (timed) set starts a window of L cycles, where L is the timer value and a value of 0 acts as 1. The strobes of the L cycles after the write are counted. After that, every counter freezes, bit 31 reads 0, bit 30 reads 1 and `irq` is high.
- R8: Bit 30 is write-one-to-clear. Writing 0 there leaves both the flag and `irq` set. Writing back the value read clears the flag and drops `irq` without starting a new window.
- R9: Setting run and timed again starts a new window of the same length from the timer register, and the counters go on from their held values.
- R10: With run set and timed clear, counting goes on until a control write with run clear. No flag and no interrupt are raised.
- R11: A write to a counter register loads the written value, so writing 0 clears it. The counters are 32 bits wide and stay at 0xFFFFFFFF instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address of the register (bits 5:2 give the index) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| arb_req | input | 1 | A request was presented this cycle |
| arb_gnt | input | 1 | A grant was issued this cycle |
| gnt_port | input | 5 | Port ID of the granted master |
| gnt_sub | input | 4 | Sub-port ID of the granted master |
| irq | output | 1 | Window-complete interrupt, held until cleared |

## Verification
A state machine stuck in the wrong state shows up at the ports on the first read after the window. A stuck TIMED state leaves bit 31 set and `irq` low. A premature EXPIRE makes the grant count fall short of L. A timer off by one cycle moves the index 10 grant total by exactly one, so the check after each window catches it within a single window. A filter that decodes the wrong mode or the wrong bit puts a grant in the wrong channel counter, and that is visible on the first read after the window.

// File: rtl/bwm_pkg.sv
`timescale 1ns/1ps
package bwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TIMED = 2'd1,
        ST_FREE  = 2'd2
    } bwm_state_e;

    localparam int IDX_CTRL      = 0;
    localparam int IDX_FILT_BASE = 1;
    localparam int IDX_ALL_REQ   = 9;
    localparam int IDX_ALL_GNT   = 10;
    localparam int IDX_CH_BASE   = 11;
    localparam int IDX_TIMER     = 15;

    localparam int BIT_RUN   = 31;
    localparam int BIT_FLAG  = 30;
    localparam int BIT_TIMED = 20;
    localparam int BIT_DEV   = 23;
endpackage

// File: rtl/bwm_sat_counter.sv
`timescale 1ns/1ps
module bwm_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr)
            cnt <= wdata;
        else if (inc && cnt != TOP)
            cnt <= cnt + 1'b1;
    end

    // R11: all-ones holds when no write is made
    a_r11_saturate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP && !wr) |=> cnt == TOP);
    // R11: below the top, one increment adds exactly one
    a_r11_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && inc && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);
    // R11: with no write and no increment the value holds
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !inc) |=> $stable(cnt));
endmodule

// File: rtl/bwm_chan_filter.sv
`timescale 1ns/1ps
module bwm_chan_filter #(
    parameter int PORT_W      = 5,
    parameter int SUB_W       = 4,
    parameter int DEV_SEL     = 23,
    parameter int DEVICE_PORT = 23
) (
    input  logic [(1<<PORT_W)-1:0] port_mask,
    input  logic [(1<<SUB_W)-1:0]  sub_mask,
    input  logic [PORT_W-1:0]      gnt_port,
    input  logic [SUB_W-1:0]       gnt_sub,
    output logic                   hit
);
    localparam logic [PORT_W-1:0] DEV_ID = PORT_W'(DEVICE_PORT);

    logic dev_mode;
    logic port_ok;
    logic sub_ok;

    always_comb begin
        dev_mode = port_mask[DEV_SEL];
        sub_ok   = sub_mask[gnt_sub];
        port_ok  = dev_mode ? (gnt_port == DEV_ID) : port_mask[gnt_port];
        hit      = port_ok && sub_ok;
    end

    // R5: in device mode no other port may match
    always_comb begin
        if (dev_mode && gnt_port != DEV_ID)
            a_r5_device_only: assert (!hit);
    end
endmodule

// File: rtl/bwm_window_fsm.sv
`timescale 1ns/1ps
module bwm_window_fsm
    import bwm_pkg::*;
#(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             wr_run,
    input  logic             wr_timed,
    input  logic             wr_clr_flag,
    input  logic [TMR_W-1:0] reload,
    output logic             active,
    output logic             flag
);
    bwm_state_e       state_q, state_d;
    logic [TMR_W-1:0] remain_q;
    logic             load;
    logic             expire;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        expire  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr && wr_run) begin
                    state_d = wr_timed ? ST_TIMED : ST_FREE;
                    load    = wr_timed;
                end
            end
            ST_TIMED: begin
                if (ctrl_wr && !wr_run) begin
                    state_d = ST_IDLE;
                end else if (ctrl_wr && !wr_timed) begin
                    state_d = ST_FREE;
                end else if (ctrl_wr) begin
                    load = 1'b1;
                end else if (remain_q <= TMR_W'(1)) begin
                    state_d = ST_IDLE;
                    expire  = 1'b1;
                end
            end
            ST_FREE: begin
                if (ctrl_wr && !wr_run) begin
                    state_d = ST_IDLE;
                end else if (ctrl_wr && wr_timed) begin
                    state_d = ST_TIMED;
                    load    = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain_q <= '0;
        else if (load)
            remain_q <= reload;
        else if (state_q == ST_TIMED && remain_q != '0)
            remain_q <= remain_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (expire)
            flag <= 1'b1;
        else if (ctrl_wr && wr_clr_flag)
            flag <= 1'b0;
    end

    always_comb begin
        active = (state_q != ST_IDLE);
    end

    // R7: expiry leaves the machine idle with the flag set
    a_r7_expire_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TIMED && !ctrl_wr && remain_q <= TMR_W'(1)) |=> (flag && state_q == ST_IDLE));
    // R7: the timer steps down by one per cycle in a running window
    a_r7_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TIMED && !ctrl_wr && remain_q > TMR_W'(1)) |=> remain_q == $past(remain_q) - 1'b1);
    // R8: only a one written to the flag bit clears it
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(ctrl_wr && wr_clr_flag)) |=> flag);
    // R10: free-running counting never raises the flag
    a_r10_free_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && state_q == ST_FREE) |=> !flag);
endmodule

// File: rtl/mem_bw_monitor.sv
`timescale 1ns/1ps
module mem_bw_monitor
    import bwm_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int CNT_W       = 32,
    parameter int PORT_W      = 5,
    parameter int SUB_W       = 4,
    parameter int ADDR_W      = 6,
    parameter int DEVICE_PORT = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              arb_req,
    input  logic              arb_gnt,
    input  logic [PORT_W-1:0] gnt_port,
    input  logic [SUB_W-1:0]  gnt_sub,
    output logic              irq
);
    localparam int PMASK_W = 1 << PORT_W;
    localparam int SMASK_W = 1 << SUB_W;
    localparam int IDX_W   = ADDR_W - 2;

    logic [IDX_W-1:0]   idx;
    logic               ctrl_wr;
    logic               active;
    logic               flag;
    logic               use_timed_q;
    logic [NUM_CH-1:0]  ch_en_q;
    logic [CNT_W-1:0]   timer_q;
    logic [PMASK_W-1:0] port_q [NUM_CH];
    logic [SMASK_W-1:0] sub_q  [NUM_CH];
    logic [NUM_CH-1:0]  hit;
    logic [CNT_W-1:0]   ch_cnt [NUM_CH];
    logic [CNT_W-1:0]   req_cnt;
    logic [CNT_W-1:0]   gnt_cnt;

    always_comb begin
        idx     = reg_addr[ADDR_W-1:2];
        ctrl_wr = reg_wr && idx == IDX_W'(IDX_CTRL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            use_timed_q <= 1'b0;
            ch_en_q     <= '0;
            timer_q     <= '0;
        end else begin
            if (ctrl_wr) begin
                use_timed_q <= reg_wdata[BIT_TIMED];
                ch_en_q     <= reg_wdata[NUM_CH-1:0];
            end
            if (reg_wr && idx == IDX_W'(IDX_TIMER))
                timer_q <= reg_wdata[CNT_W-1:0];
        end
    end

    bwm_window_fsm #(.TMR_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .wr_run      (reg_wdata[BIT_RUN]),
        .wr_timed    (reg_wdata[BIT_TIMED]),
        .wr_clr_flag (reg_wdata[BIT_FLAG]),
        .reload      (timer_q),
        .active      (active),
        .flag        (flag)
    );

    bwm_sat_counter #(.W(CNT_W)) u_req_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr && idx == IDX_W'(IDX_ALL_REQ)),
        .wdata (reg_wdata[CNT_W-1:0]),
        .inc   (active && arb_req),
        .cnt   (req_cnt)
    );

    bwm_sat_counter #(.W(CNT_W)) u_gnt_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr && idx == IDX_W'(IDX_ALL_GNT)),
        .wdata (reg_wdata[CNT_W-1:0]),
        .inc   (active && arb_gnt),
        .cnt   (gnt_cnt)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam int PIDX = IDX_FILT_BASE + 2 * n;
        localparam int SIDX = IDX_FILT_BASE + 2 * n + 1;
        localparam int CIDX = IDX_CH_BASE + n;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                port_q[n] <= '0;
                sub_q[n]  <= '0;
            end else if (reg_wr) begin
                if (idx == IDX_W'(PIDX))
                    port_q[n] <= reg_wdata[PMASK_W-1:0];
                if (idx == IDX_W'(SIDX))
                    sub_q[n] <= reg_wdata[SMASK_W-1:0];
            end
        end

        bwm_chan_filter #(
            .PORT_W      (PORT_W),
            .SUB_W       (SUB_W),
            .DEV_SEL     (BIT_DEV),
            .DEVICE_PORT (DEVICE_PORT)
        ) u_filt (
            .port_mask (port_q[n]),
            .sub_mask  (sub_q[n]),
            .gnt_port  (gnt_port),
            .gnt_sub   (gnt_sub),
            .hit       (hit[n])
        );

        bwm_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (reg_wr && idx == IDX_W'(CIDX)),
            .wdata (reg_wdata[CNT_W-1:0]),
            .inc   (active && arb_gnt && ch_en_q[n] && hit[n]),
            .cnt   (ch_cnt[n])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (idx == IDX_W'(IDX_CTRL)) begin
            reg_rdata[BIT_RUN]      = active;
            reg_rdata[BIT_FLAG]     = flag;
            reg_rdata[BIT_TIMED]    = use_timed_q;
            reg_rdata[NUM_CH-1:0]   = ch_en_q;
        end else if (idx == IDX_W'(IDX_ALL_REQ)) begin
            reg_rdata[CNT_W-1:0] = req_cnt;
        end else if (idx == IDX_W'(IDX_ALL_GNT)) begin
            reg_rdata[CNT_W-1:0] = gnt_cnt;
        end else if (idx == IDX_W'(IDX_TIMER)) begin
            reg_rdata[CNT_W-1:0] = timer_q;
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (idx == IDX_W'(IDX_FILT_BASE + 2 * n))
                reg_rdata[PMASK_W-1:0] = port_q[n];
            if (idx == IDX_W'(IDX_FILT_BASE + 2 * n + 1))
                reg_rdata[SMASK_W-1:0] = sub_q[n];
            if (idx == IDX_W'(IDX_CH_BASE + n))
                reg_rdata[CNT_W-1:0] = ch_cnt[n];
        end
    end

    always_comb begin
        irq = flag;
    end

    // R3: a stopped monitor leaves the global grant count alone
    a_r3_stopped_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !reg_wr) |=> $stable(gnt_cnt));
    // R6: a disabled channel never advances without a write
    a_r6_disabled_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_en_q[0] && !reg_wr) |=> $stable(ch_cnt[0]));
endmodule

// File: tb/tb_mem_bw_monitor.sv
`timescale 1ns/1ps
module tb_mem_bw_monitor;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        arb_req = 1'b0;
    logic        arb_gnt = 1'b0;
    logic [4:0]  gnt_port = '0;
    logic [3:0]  gnt_sub = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [5:0]  addr;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    mem_bw_monitor dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .arb_req   (arb_req),
        .arb_gnt   (arb_gnt),
        .gnt_port  (gnt_port),
        .gnt_sub   (gnt_sub),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: pops one expected item per cycle, one time unit after the edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h",
                         it.tag, it.addr, act, it.exp);
            end
        end
    end

    task automatic wr_reg(input int index, input logic [31:0] data);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = 6'(index * 4);
        reg_wdata = data;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic expect_reg(input int index, input logic [31:0] exp, input string tag);
        sb_item_t it;
        @(negedge clk);
        reg_wr   = 1'b0;
        reg_addr = 6'(index * 4);
        it.is_irq = 1'b0;
        it.addr   = 6'(index * 4);
        it.exp    = exp;
        it.tag    = tag;
        sb_q.push_back(it);
        @(posedge clk);
        #2;
    endtask

    task automatic expect_irq(input bit exp, input string tag);
        sb_item_t it;
        @(negedge clk);
        it.is_irq = 1'b1;
        it.addr   = '0;
        it.exp    = {31'b0, exp};
        it.tag    = tag;
        sb_q.push_back(it);
        @(posedge clk);
        #2;
    endtask

    task automatic traffic(input bit rq, input bit gt, input logic [4:0] p,
                           input logic [3:0] s, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            arb_req  = rq;
            arb_gnt  = gt;
            gnt_port = p;
            gnt_sub  = s;
        end
        @(negedge clk);
        arb_req = 1'b0;
        arb_gnt = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_reg(0, 32'h0, "R1 control");
        expect_reg(10, 32'h0, "R1 grant count");
        expect_reg(15, 32'h0, "R1 timer");
        expect_irq(1'b0, "R1 irq");

        // R2 register layout and widths
        wr_reg(4, 32'hABCD_FFFF);
        expect_reg(4, 32'h0000_FFFF, "R2 sub-port width");
        wr_reg(7, 32'h1234_5678);
        expect_reg(7, 32'h1234_5678, "R2 port register ch3");

        // channel filters: ch0 port3 all subs, ch1 device sub2, ch2 port3 sub0, ch3 port3 (disabled)
        wr_reg(1, 32'h0000_0008); wr_reg(2, 32'h0000_FFFF);
        wr_reg(3, 32'h0080_0000); wr_reg(4, 32'h0000_0004);
        wr_reg(5, 32'h0000_0008); wr_reg(6, 32'h0000_0001);
        wr_reg(7, 32'h0000_0008); wr_reg(8, 32'h0000_FFFF);
        wr_reg(15, 32'd5);
        expect_reg(15, 32'd5, "R2 timer readback");

        // R7 timed window of 5 cycles, traffic port 3 sub 2
        wr_reg(0, 32'h8010_0007);
        traffic(1'b1, 1'b1, 5'd3, 4'd2, 10);
        expect_reg(10, 32'd5, "R7 grants in window");
        expect_reg(9, 32'd5, "R3 requests in window");
        expect_reg(11, 32'd5, "R4 port match ch0");
        expect_reg(12, 32'd0, "R5 device mode rejects port 3");
        expect_reg(13, 32'd0, "R4 sub-port miss ch2");
        expect_reg(14, 32'd0, "R6 disabled ch3");
        expect_reg(0, 32'h4010_0007, "R7 control after window");
        expect_irq(1'b1, "R7 irq raised");

        // R8 write-one-to-clear
        wr_reg(0, 32'h0010_0007);
        expect_irq(1'b1, "R8 zero leaves flag");
        wr_reg(0, 32'h4010_0007);
        expect_irq(1'b0, "R8 irq cleared");
        expect_reg(0, 32'h0010_0007, "R8 control after clear");

        // R9 second window from the same timer value, device traffic
        wr_reg(0, 32'h8010_0007);
        traffic(1'b1, 1'b1, 5'd23, 4'd2, 8);
        expect_reg(10, 32'd10, "R9 grants accumulate");
        expect_reg(12, 32'd5, "R5 device match ch1");
        expect_reg(11, 32'd5, "R4 port mismatch ch0");
        expect_reg(15, 32'd5, "R9 timer kept");
        expect_irq(1'b1, "R9 irq second window");
        wr_reg(0, 32'h4000_0000);
        expect_irq(1'b0, "R8 cleared again");

        // R10 free-running mode; R11 clears by writing zero
        wr_reg(9, 32'h0); wr_reg(10, 32'h0); wr_reg(11, 32'h0);
        expect_reg(10, 32'h0, "R11 write zero clears");
        wr_reg(0, 32'h8000_0001);
        traffic(1'b1, 1'b0, 5'd3, 4'd0, 3);
        traffic(1'b1, 1'b1, 5'd3, 4'd0, 4);
        wr_reg(0, 32'h0);
        expect_reg(9, 32'd7, "R10 free requests");
        expect_reg(10, 32'd4, "R10 free grants");
        expect_reg(11, 32'd4, "R10 free ch0");
        expect_reg(0, 32'h0, "R10 control stopped");
        expect_irq(1'b0, "R10 no irq");
        traffic(1'b1, 1'b1, 5'd3, 4'd0, 3);
        expect_reg(10, 32'd4, "R3 stopped no count");

        // R11 saturation
        wr_reg(10, 32'hFFFF_FFFE);
        wr_reg(0, 32'h8000_0000);
        traffic(1'b0, 1'b1, 5'd1, 4'd0, 3);
        wr_reg(0, 32'h0);
        expect_reg(10, 32'hFFFF_FFFF, "R11 saturates");
        wr_reg(10, 32'h0);
        expect_reg(10, 32'h0, "R11 clear after saturation");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule